// File: doc/BRIEF.md
# Partitioned SIMD Adder

This block is a 64-bit adder whose single carry chain can be cut at run time into several narrower, independent adders. A two-bit mode input selects eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit add. The two operands arrive as packed words, with each element in consecutive bits. Every lane always produces a result: there is no per-lane enable and no length register.

The chain is built from 8-bit segments. At each lane boundary the carry into the next segment is replaced by the lane's own carry-in. That carry-in is 0 for an add and 1 for a subtract, and a subtract also inverts the second operand. Each lane's sum wraps modulo 2^width. The carry out of each lane is reported as a flag and is never applied to anything. The result, the flags and a valid bit are registered one cycle after the input strobe.

Top module: `simd_part_add`

## Requirements
- R1: While rst_ni is low and after its release with no input strobe, valid_o, sum_o and cout_o are all zero.
- R2: valid_o is high exactly one clock after a cycle with valid_i high. sum_o and cout_o update on that same edge.
- R3: With mode_i = 2'b00 the word holds eight 8-bit lanes. Lane j occupies bits 8j+7..8j and its result is a lane sum modulo 2^8.
- R4: With mode_i = 2'b01 the word holds four 16-bit lanes. Lane j occupies bits 16j+15..16j and its result is a lane sum modulo 2^16.
- R5: With mode_i = 2'b10 the word holds two 32-bit lanes. Lane j occupies bits 32j+31..32j and its result is a lane sum modulo 2^32.
- R6: With mode_i = 2'b11 the block performs one 64-bit add modulo 2^64.
- R7: With sub_i = 1 each lane computes a - b modulo 2^width, formed as a + ~b + 1, with the 1 injected at the lane's least significant bit.
- R8: cout_o[j] is the carry out of the top bit of lane j. For a subtract, 1 means no borrow. Bits of cout_o at or above the lane count are 0.
- R9: No carry crosses a lane boundary. An all-ones lane plus 1 gives 0 in that lane and leaves the next lane unchanged.
- R10: In a cycle with valid_i low, valid_o falls on the next edge and sum_o and cout_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input strobe |
| mode_i | input | 2 | Lane width select: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| a_i | input | 64 | Packed first operand |
| b_i | input | 64 | Packed second operand |
| valid_o | output | 1 | Result valid |
| sum_o | output | 64 | Packed lane results |
| cout_o | output | 8 | Per-lane carry-out flags, lane 0 in bit 0 |

## Verification
The assertions assume that mode_i, sub_i and the operands are stable and known whenever valid_i is sampled high. They also assume that valid_i is low while reset is held. The bench drives every input on the falling clock edge and holds valid_i low throughout reset, so both assumptions hold.

The stimulus covers all four modes with both add and subtract. It places carry-rippling all-ones patterns at every lane boundary, applies operands with the top bit set to exercise the flags, and inserts idle cycles carrying garbage operands to show that the outputs hold.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  localparam int SEG_W = 8;
  localparam int NSEG  = 8;
  localparam int MODE_W = $clog2($clog2(NSEG) + 1);

  typedef enum logic [MODE_W-1:0] {
    LANE_B8  = 2'd0,
    LANE_B16 = 2'd1,
    LANE_B32 = 2'd2,
    LANE_B64 = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] full;
  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
endmodule

// File: rtl/simd_lane_ctl.sv
module simd_lane_ctl #(
  parameter int NSEG   = 8,
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [NSEG-1:0]   seg_cout_i,
  output logic [NSEG-1:0]   head_o,
  output logic [NSEG-1:0]   flag_o
);
  logic [NSEG-1:0] tail;
  int unsigned spl;

  always_comb begin
    spl = 1 << mode_i;
    head_o = '0;
    tail   = '0;
    flag_o = '0;
    for (int k = 0; k < NSEG; k++) begin
      head_o[k] = ((k & (spl - 1)) == 0);
      tail[k]   = ((k & (spl - 1)) == spl - 1);
      // lane index of a tail segment is k / spl
      if (tail[k]) flag_o[k >> mode_i] = seg_cout_i[k];
    end
  end
endmodule

// File: rtl/simd_part_add.sv
module simd_part_add
  import simd_add_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int NS = NSEG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic              sub_i,
  input  logic [SW*NS-1:0]  a_i,
  input  logic [SW*NS-1:0]  b_i,
  output logic              valid_o,
  output logic [SW*NS-1:0]  sum_o,
  output logic [NS-1:0]     cout_o
);
  localparam int DW = SW * NS;

  logic [DW-1:0] b_eff, sum_d;
  logic [NS-1:0] seg_cin, seg_cout, head, flag_d;
  logic [1:0]    mode_q;

  assign b_eff = sub_i ? ~b_i : b_i;

  simd_lane_ctl #(.NSEG(NS), .MODE_W(2)) u_ctl (
    .mode_i     (mode_i),
    .seg_cout_i (seg_cout),
    .head_o     (head),
    .flag_o     (flag_d)
  );

  for (genvar k = 0; k < NS; k++) begin : g_seg
    if (k == 0) begin : g_first
      assign seg_cin[k] = sub_i;
    end else begin : g_rest
      // lane head takes the op carry-in, else the chain continues
      assign seg_cin[k] = head[k] ? sub_i : seg_cout[k-1];
    end
    simd_seg_add #(.W(SW)) u_seg (
      .a_i    (a_i[k*SW +: SW]),
      .b_i    (b_eff[k*SW +: SW]),
      .cin_i  (seg_cin[k]),
      .sum_o  (sum_d[k*SW +: SW]),
      .cout_o (seg_cout[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      cout_o  <= '0;
      mode_q  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o  <= sum_d;
        cout_o <= flag_d;
        mode_q <= mode_i;
      end
    end
  end

  // R2
  valid_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(sum_o) && $stable(cout_o)));

  // R6
  full_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == LANE_B64 && !sub_i) |=> sum_o == $past(a_i + b_i));

  // R7
  low_lane_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mode_i == LANE_B8 && sub_i) |=>
      sum_o[SW-1:0] == $past(a_i[SW-1:0] - b_i[SW-1:0]));

  // R8
  unused_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cout_o >> (NS >> mode_q)) == '0);
endmodule

// File: tb/sim_simd_part_add.sv
module sim_simd_part_add;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, sub_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] sum_o;
  logic [7:0]  cout_o;

  int checks = 0, errors = 0;
  logic [63:0] exp_sum = '0;
  logic [7:0]  exp_cout = '0;

  always #2.5 clk = ~clk;

  simd_part_add u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .sub_i(sub_i), .a_i(a_i), .b_i(b_b_fix), .valid_o(valid_o),
    .sum_o(sum_o), .cout_o(cout_o)
  );
  wire [63:0] b_b_fix = b_i;

  task automatic model(input logic [1:0] m, input logic s,
                       input logic [63:0] a, input logic [63:0] b);
    int w, n;
    logic [64:0] mask, av, bv, t;
    w = 8 << m;
    n = 8 >> m;
    mask = (65'd1 << w) - 65'd1;
    exp_sum = '0;
    exp_cout = '0;
    for (int j = 0; j < n; j++) begin
      av = ({1'b0, a} >> (j * w)) & mask;
      bv = ({1'b0, b} >> (j * w)) & mask;
      if (s) bv = (~bv) & mask;
      t = av + bv + {64'd0, s};
      exp_sum = exp_sum | 64'((t & mask) << (j * w));
      exp_cout[j] = t[w];
    end
  endtask

  task automatic cmp(input string req, input logic ev);
    checks++;
    if (valid_o !== ev || sum_o !== exp_sum || cout_o !== exp_cout) begin
      errors++;
      $display("FAIL %s: valid=%b sum=%h cout=%h expected valid=%b sum=%h cout=%h",
               req, valid_o, sum_o, cout_o, ev, exp_sum, exp_cout);
    end
  endtask

  task automatic op(input string req, input logic [1:0] m, input logic s,
                    input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; sub_i = s; a_i = a; b_i = b;
    model(m, s, a, b);
    @(negedge clk);
    valid_i = 1'b0;
    cmp(req, 1'b1);
  endtask

  task automatic idle(input string req, input logic [63:0] junk);
    @(negedge clk);
    valid_i = 1'b0; a_i = junk; b_i = ~junk; sub_i = junk[0]; mode_i = junk[2:1];
    @(negedge clk);
    cmp(req, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 in reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 after release", 1'b0);

    op("R3 R2 add8", 2'd0, 1'b0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010);
    op("R3 R8 add8 carries", 2'd0, 1'b0, 64'h80FF_7F01_C0A0_FF00, 64'h8001_8101_4060_FF00);
    op("R9 add8 ripple stop", 2'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
    op("R7 sub8", 2'd0, 1'b1, 64'h0010_2030_4050_6070, 64'h0101_0101_0101_0171);
    op("R4 add16", 2'd1, 1'b0, 64'hFFFF_1234_8000_00FF, 64'h0001_1111_8000_0001);
    op("R9 add16 ripple stop", 2'd1, 1'b0, 64'h00FF_FFFF_00FF_FFFF, 64'h0000_0001_0000_0001);
    op("R7 sub16", 2'd1, 1'b1, 64'h0000_1000_8000_FFFF, 64'h0001_0001_7FFF_FFFF);
    op("R5 add32", 2'd2, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0000_0001_8000_0001);
    op("R7 sub32", 2'd2, 1'b1, 64'h0000_0000_1234_5678, 64'h0000_0001_0000_0001);
    op("R6 add64", 2'd3, 1'b0, 64'h00FF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    op("R6 R8 add64 carry", 2'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002);
    op("R7 sub64", 2'd3, 1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001);
    idle("R10 hold", 64'hDEAD_BEEF_CAFE_F00D);
    idle("R10 hold again", 64'h5555_AAAA_5555_AAAA);
    op("R8 sub8 no borrow flags", 2'd0, 1'b1, 64'hFF00_FF00_FF00_FF00, 64'h00FF_00FF_00FF_00FF);

    for (int i = 0; i < 64; i++) begin
      logic [63:0] a, b;
      a = {32'(i * 32'h9E37_79B9), 32'(i * 32'h85EB_CA6B)};
      b = {32'(i * 32'hC2B2_AE35), 32'(~i * 32'h27D4_EB2F)};
      op("R3 R4 R5 R6 R7 sweep", 2'(i), i[2], a, b);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule